// File: doc/BRIEF.md
# Programmable CPU and Bus Clock Divider

This block derives three related timing strobes from a single fast reference clock. One 2-bit selector chooses a prescale of the reference by 16, 4, 2 or 1. A CPU divider then divides that prescaled rate by an integer from 2 to 16. Two bus dividers, one for the DMA fabric and one for the memory-mapped register bus, each divide the CPU rate by a further integer from 2 to 16. The design targets synthesis, so it generates no clocks of its own. Each output is a one-reference-cycle enable pulse, and downstream logic clocked by the reference uses these pulses to qualify its updates.

Firmware programs all three ratios through one 16-bit configuration word. The block checks every write. A write that zeroes a divider field, or that gives a memory-mapped ratio which is not a whole multiple of the DMA ratio, is rejected and raises an error flag. A legal write is staged and takes effect only at the next cycle where every counter in the chain wraps at once. As a result, no output period is ever cut short or stretched.

Top module: `cpu_bus_clkdiv`

## Requirements
- R1: After reset, the read-back word is 0x1131 and the error flag is low. cpu_en pulses every 2 reference cycles, and dma_en and mmio_en pulse every 4.
- R2: Word bits 5:4 select the prescale. 00 divides the reference by 16, 01 by 4, 10 by 2, and 11 passes it undivided.
- R3: Word bits 3:0 hold c. The cpu_en period is prescale × (c+1) reference cycles.
- R4: Word bits 11:8 hold d. The dma_en period is the cpu_en period × (d+1).
- R5: Word bits 15:12 hold m. The mmio_en period is the cpu_en period × (m+1).
- R6: The read-back word equals the last accepted write, with bits 7:6 always read as 0.
- R7: A write with c, d or m equal to 0 sets the error flag in the next cycle. It leaves the read-back word and all output periods unchanged.
- R8: A write where (m+1) is not an integer multiple of (d+1) is rejected in the same way as R7.
- R9: The error flag stays high until the next legal write, which clears it in the following cycle.
- R10: A staged setting becomes active only in a cycle in which mmio_en pulses. Every pulse interval therefore matches either the old setting or the new setting in full.
- R11: Every dma_en pulse coincides with a cpu_en pulse, and every mmio_en pulse coincides with a dma_en pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_rdata | output | 16 | Last accepted configuration word |
| cfg_err | output | 1 | Sticky flag for a rejected write |
| cpu_en | output | 1 | CPU-rate enable pulse |
| dma_en | output | 1 | DMA bus enable pulse |
| mmio_en | output | 1 | Register bus enable pulse |

## Verification
The write-check assertions assume that cfg_wdata is stable and known whenever cfg_we is high. They also assume that rst is held for at least one clock, so that the read-back check in the first cycle after reset sees the default word. The stimulus changes the write word only at the falling edge and raises the strobe for exactly one rising edge. Random settings are drawn so that the bus ratios always satisfy the multiple rule, and rejected words are applied only as separate directed writes. Random settings are also capped in total period, so each one produces several complete bus intervals.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    localparam int DIV_W    = 4;
    localparam int SEL_W    = 2;
    localparam int PRE_W    = 4;
    localparam int CFG_W    = 4 * DIV_W;
    localparam int CPU_LSB  = 0;
    localparam int SRC_LSB  = DIV_W;
    localparam int RSV_LSB  = DIV_W + SEL_W;
    localparam int RSV_W    = DIV_W - SEL_W;
    localparam int DMA_LSB  = 2 * DIV_W;
    localparam int MMIO_LSB = 3 * DIV_W;
    localparam int NUM_BUS  = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_DIV16  = 2'b00,
        SRC_DIV4   = 2'b01,
        SRC_DIV2   = 2'b10,
        SRC_DIRECT = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic [DIV_W-1:0] mmio_div;
        logic [DIV_W-1:0] dma_div;
        src_sel_e         src;
        logic [DIV_W-1:0] cpu_div;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        mmio_div: DIV_W'(1),
        dma_div:  DIV_W'(1),
        src:      SRC_DIRECT,
        cpu_div:  DIV_W'(1)
    };

    function automatic cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
        cfg_t c;
        c.cpu_div  = w[CPU_LSB  +: DIV_W];
        c.src      = src_sel_e'(w[SRC_LSB +: SEL_W]);
        c.dma_div  = w[DMA_LSB  +: DIV_W];
        c.mmio_div = w[MMIO_LSB +: DIV_W];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_pack(input cfg_t c);
        logic [CFG_W-1:0] w;
        w                      = '0;
        w[CPU_LSB  +: DIV_W]   = c.cpu_div;
        w[SRC_LSB  +: SEL_W]   = c.src;
        w[RSV_LSB  +: RSV_W]   = '0;
        w[DMA_LSB  +: DIV_W]   = c.dma_div;
        w[MMIO_LSB +: DIV_W]   = c.mmio_div;
        return w;
    endfunction

    // Divider fields must be non-zero; the register-bus ratio must be a
    // whole multiple of the DMA ratio so their pulses stay aligned.
    function automatic logic cfg_legal(input cfg_t c);
        logic [DIV_W:0] mmio_ratio;
        logic [DIV_W:0] dma_ratio;
        mmio_ratio = {1'b0, c.mmio_div} + 1'b1;
        dma_ratio  = {1'b0, c.dma_div}  + 1'b1;
        return (c.cpu_div != '0) && (c.dma_div != '0) && (c.mmio_div != '0)
            && ((mmio_ratio % dma_ratio) == '0);
    endfunction

    // Low-bit mask whose all-ones state marks one prescaled tick.
    function automatic logic [PRE_W-1:0] prescale_mask(input src_sel_e s);
        logic [PRE_W-1:0] m;
        case (s)
            SRC_DIV16:  m = PRE_W'(15);
            SRC_DIV4:   m = PRE_W'(3);
            SRC_DIV2:   m = PRE_W'(1);
            default:    m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/clkdiv_cfg_reg.sv
`timescale 1ns/1ps
module clkdiv_cfg_reg
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             boundary,
    output cfg_t             act_cfg,
    output logic [CFG_W-1:0] rdata,
    output logic             err
);

    cfg_t staged_q;
    cfg_t active_q;
    logic pend_q;
    logic err_q;
    cfg_t wr_cfg;
    logic wr_ok;

    always_comb begin
        wr_cfg = cfg_unpack(wdata);
        wr_ok  = cfg_legal(wr_cfg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= CFG_RESET;
            active_q <= CFG_RESET;
            pend_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (boundary && pend_q) begin
                active_q <= staged_q;
                pend_q   <= 1'b0;
            end
            if (we) begin
                if (wr_ok) begin
                    staged_q <= wr_cfg;
                    pend_q   <= 1'b1;
                    err_q    <= 1'b0;
                end else begin
                    err_q    <= 1'b1;
                end
            end
        end
    end

    assign act_cfg = active_q;
    assign rdata   = cfg_pack(staged_q);
    assign err     = err_q;

endmodule

// File: rtl/clkdiv_prescale.sv
`timescale 1ns/1ps
module clkdiv_prescale
    import clkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_sel_e sel,
    input  logic     restart,
    output logic     tick
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] mask;

    assign mask = prescale_mask(sel);
    assign tick = ((cnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/clkdiv_stage.sv
`timescale 1ns/1ps
module clkdiv_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         pulse
);

    logic [W-1:0] cnt_q;
    logic         at_end;

    assign at_end = (cnt_q >= limit);
    assign pulse  = tick && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cpu_bus_clkdiv.sv
`timescale 1ns/1ps
module cpu_bus_clkdiv
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             cfg_err,
    output logic             cpu_en,
    output logic             dma_en,
    output logic             mmio_en
);

    cfg_t               act_cfg;
    logic               src_tick;
    logic [DIV_W-1:0]   bus_lim [NUM_BUS];
    logic [NUM_BUS-1:0] bus_pulse;

    clkdiv_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .boundary (mmio_en),
        .act_cfg  (act_cfg),
        .rdata    (cfg_rdata),
        .err      (cfg_err)
    );

    clkdiv_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .sel     (act_cfg.src),
        .restart (mmio_en),
        .tick    (src_tick)
    );

    clkdiv_stage #(.W(DIV_W)) u_cpu (
        .clk   (clk),
        .rst   (rst),
        .tick  (src_tick),
        .limit (act_cfg.cpu_div),
        .pulse (cpu_en)
    );

    assign bus_lim[0] = act_cfg.dma_div;
    assign bus_lim[1] = act_cfg.mmio_div;

    for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
        clkdiv_stage #(.W(DIV_W)) u_bus (
            .clk   (clk),
            .rst   (rst),
            .tick  (cpu_en),
            .limit (bus_lim[g]),
            .pulse (bus_pulse[g])
        );
    end

    assign dma_en  = bus_pulse[0];
    assign mmio_en = bus_pulse[1];

endmodule

// File: rtl/clkdiv_chk.sv
`timescale 1ns/1ps
module clkdiv_chk
    import clkdiv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             cfg_err,
    input logic             cpu_en,
    input logic             dma_en,
    input logic             mmio_en,
    input cfg_t             act_cfg
);

    // R1
    reset_word_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_rdata == cfg_pack(CFG_RESET)) && !cfg_err);

    // R11
    dma_in_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        dma_en |-> cpu_en);

    // R11
    mmio_in_dma_chk: assert property (@(posedge clk) disable iff (rst)
        mmio_en |-> dma_en);

    // R6
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[RSV_LSB +: RSV_W] == '0);

    // R7 R8
    bad_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_legal(cfg_unpack(cfg_wdata))) |=> cfg_err && $stable(cfg_rdata));

    // R9
    good_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_legal(cfg_unpack(cfg_wdata)))
            |=> !cfg_err && (cfg_rdata == cfg_pack(cfg_unpack($past(cfg_wdata)))));

    // R10
    switch_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !mmio_en |=> $stable(act_cfg));

endmodule

bind cpu_bus_clkdiv clkdiv_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_err   (cfg_err),
    .cpu_en    (cpu_en),
    .dma_en    (dma_en),
    .mmio_en   (mmio_en),
    .act_cfg   (act_cfg)
);

// File: tb/test_cpu_bus_clkdiv.sv
`timescale 1ns/1ps
module test_cpu_bus_clkdiv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        cfg_err;
    logic        cpu_en;
    logic        dma_en;
    logic        mmio_en;

    always #5 clk = ~clk;

    cpu_bus_clkdiv i_cpu_bus_clkdiv (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_err   (cfg_err),
        .cpu_en    (cpu_en),
        .dma_en    (dma_en),
        .mmio_en   (mmio_en)
    );

    typedef struct {
        longint cpu;
        longint dma;
        longint mmio;
    } exp_t;

    exp_t   exp_q[$];
    exp_t   cur;
    int     tests = 0;
    int     fails = 0;
    longint cyc = 0;
    longint last_c = 0, last_d = 0, last_m = 0;
    bit     v_c = 0, v_d = 0, v_m = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2: 00 -> /16, 01 -> /4, 10 -> /2, 11 -> /1; R3..R5 ratios multiply.
    function automatic exp_t expect_of(input logic [15:0] v);
        exp_t   e;
        longint p;
        case (v[5:4])
            2'b00:   p = 16;
            2'b01:   p = 4;
            2'b10:   p = 2;
            default: p = 1;
        endcase
        e.cpu  = p * (longint'(v[3:0]) + 1);
        e.dma  = e.cpu * (longint'(v[11:8]) + 1);
        e.mmio = e.cpu * (longint'(v[15:12]) + 1);
        return e;
    endfunction

    // Monitor: measures every pulse interval and compares it with the
    // setting in force; a queued setting is adopted at the next mmio pulse (R10).
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (dma_en)  check(cpu_en, "R11 dma_en without cpu_en", cpu_en, 1);
            if (mmio_en) check(dma_en, "R11 mmio_en without dma_en", dma_en, 1);
            if (cpu_en) begin
                if (v_c) check(cyc - last_c == cur.cpu, "R2/R3/R10 cpu period", cyc - last_c, cur.cpu);
                last_c = cyc; v_c = 1;
            end
            if (dma_en) begin
                if (v_d) check(cyc - last_d == cur.dma, "R4/R10 dma period", cyc - last_d, cur.dma);
                last_d = cyc; v_d = 1;
            end
            if (mmio_en) begin
                if (v_m) check(cyc - last_m == cur.mmio, "R5/R10 mmio period", cyc - last_m, cur.mmio);
                last_m = cyc; v_m = 1;
                if (exp_q.size() > 0) cur = exp_q.pop_front();
            end
        end
    end

    task automatic wait_mmio(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!mmio_en) @(negedge clk);
        end
    endtask

    // Driver: writes a legal word and queues its expected periods.
    task automatic apply_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        exp_q.push_back(expect_of(v));
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_rdata == (v & 16'hFF3F), "R6 readback", cfg_rdata, v & 16'hFF3F);
        check(cfg_err == 1'b0, "R9 err cleared by legal write", cfg_err, 0);
        wait_mmio(3);
    endtask

    task automatic reject_cfg(input logic [15:0] v, input string req);
        logic [15:0] prev;
        prev = cfg_rdata;
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_err == 1'b1, {req, " err raised"}, cfg_err, 1);
        check(cfg_rdata == prev, {req, " readback held"}, cfg_rdata, prev);
        wait_mmio(2);
        check(cfg_err == 1'b1, "R9 err sticky", cfg_err, 1);
    endtask

    initial begin
        #1_500_000;
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cur = '{cpu: 2, dma: 4, mmio: 4};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(cfg_rdata == 16'h1131, "R1 reset readback", cfg_rdata, 16'h1131);
        check(cfg_err == 1'b0, "R1 reset err", cfg_err, 0);
        wait_mmio(3);

        // R2 each prescale select
        apply_cfg(16'h1101);
        apply_cfg(16'h3112);
        apply_cfg(16'h5223);
        apply_cfg(16'h7333);
        // R6 reserved bits written as ones read zero
        apply_cfg(16'hFFFF);

        // R7 zero fields, R8 broken multiple
        reject_cfg(16'h1130, "R7 cpu zero");
        reject_cfg(16'h1031, "R7 dma zero");
        reject_cfg(16'h0131, "R7 mmio zero");
        reject_cfg(16'h5331, "R8 not a multiple");
        apply_cfg(16'h3121);

        // Random legal settings
        for (int n = 0; n < 12; n++) begin
            int sel, c, d, m, k, p;
            do begin
                sel = $urandom_range(0, 3);
                c   = $urandom_range(1, 15);
                d   = $urandom_range(1, 7);
                k   = $urandom_range(1, 16 / (d + 1));
                m   = k * (d + 1) - 1;
                p   = (sel == 0) ? 16 : (sel == 1) ? 4 : (sel == 2) ? 2 : 1;
            end while (p * (c + 1) * (m + 1) > 2000);
            apply_cfg({m[3:0], d[3:0], 2'b00, sel[1:0], c[3:0]});
        end

        wait_mmio(1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule